// File: doc/BRIEF.md
# I2C Calibration Code Register with Non-Volatile Copy

This block is a two-wire serial slave that holds a 7-bit calibration code for an external current-sink digital-to-analog stage. Its 128 levels run from 0 to 127, and a larger code asks for more sink current, which lowers the voltage that the divider produces. The code lives in a volatile register that drives `dacCode` directly. On command, the code can be copied into a non-volatile store. That store is modelled as a register that only the power-on reset clears, and it reports a busy window while the copy is written.

The bus lines are sampled on the system clock. The block sees its own pull-down on the wired line and drives SDA only through an open-drain enable. A master addresses the block at the fixed 7-bit address 1001111. A write transfer carries a command byte, which either opens a stream of code bytes or requests a save to the store. A read transfer returns the live code, then the stored code, and keeps alternating between them for as long as the master acknowledges. Writes take effect only while the write-protect input is high. Whenever the functional reset is released, the live code is reloaded from the store.

Top module: `calib_i2c_slave`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits are 1001111, with bit 0 as the direction (1 = read). Any other address is not acknowledged, and the block ignores the bus until the next start or stop.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A start seen mid-transfer restarts address matching. A stop returns the block to idle with SDA released.
- R3: The block acknowledges a received byte by pulling SDA low during the ninth clock. It changes its SDA drive only while SCL is low.
- R4: After command byte 0x00, every following byte is acknowledged and its low seven bits are loaded into the live code. Bit 7 of each such byte is ignored.
- R5: Command byte 0x80 is acknowledged and copies the live code into the store.
- R6: The write-protect level is taken at the eighth data bit of a write byte. If it is low there, the byte is still acknowledged, but neither the live code nor the store changes and no busy window starts.
- R7: After the functional reset is released, the live code equals the stored code. The power-on reset sets the store to `NV_INIT`.
- R8: A read transfer returns {0, live code} first and {0, stored code} second, then alternates between the two while the master acknowledges.
- R9: When the master does not acknowledge a read byte, the block releases SDA and drives nothing more until the next start.
- R10: An accepted save raises `storeBusy` for `STORE_CYCLES` clocks. While `storeBusy` is high, the block does not acknowledge its address.
- R11: A command byte other than 0x00 or 0x80 is not acknowledged, and the rest of that transfer is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rstN | input | 1 | Synchronous functional reset, active low; reloads the live code from the store |
| porN | input | 1 | Synchronous power-on reset, active low; sets the store to NV_INIT |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level, as seen on the wired bus |
| wpIn | input | 1 | Write enable, high to allow writes |
| sdaPullLow | output | 1 | Open-drain enable; high pulls SDA low |
| dacCode | output | 7 | Live calibration code |
| storeBusy | output | 1 | High while a save to the store is in progress |

## Verification
A wrong bit counter or wrong control state shows up at the ports within one byte time. Either the acknowledge arrives in the wrong clock, or data read back from the block shifts by one bit. A wrong strobe or a missed write-protect sample shows on `dacCode` as soon as the stop of the transfer has completed, or on the second byte of the next read. A fault in the busy window or in the reset recall shows on the next address byte, or in the first cycle after the functional reset is released.

// File: rtl/calib_pkg.sv
package calib_pkg;
  localparam int CODE_W = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_DATA,
    ST_READ,
    ST_SKIP
  } busState_t;

  typedef struct packed {
    logic              dacWr;
    logic              storeWr;
    logic [CODE_W-1:0] code;
  } calStrobe_t;
endpackage

// File: rtl/calib_ctrl.sv
module calib_ctrl
  import calib_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'b1001111,
  parameter logic [7:0] CMD_DAC   = 8'h00,
  parameter logic [7:0] CMD_STORE = 8'h80,
  parameter int         SYNC_LEN  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              wpIn,
  input  logic              busy,
  input  logic [CODE_W-1:0] dacCode,
  input  logic [CODE_W-1:0] nvCode,
  output logic              sdaPullLow,
  output calStrobe_t        strobe
);
  logic [SYNC_LEN-1:0] sclSync, sdaSync;
  logic sclPrev, sdaPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_LEN-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_LEN-2:0], sdaIn};
      sclPrev <= sclSync[SYNC_LEN-1];
      sdaPrev <= sdaSync[SYNC_LEN-1];
    end
  end

  logic sclS, sdaS, sclRise, sclFall, startSeen, stopSeen;
  assign sclS      = sclSync[SYNC_LEN-1];
  assign sdaS      = sdaSync[SYNC_LEN-1];
  assign sclRise   = sclS & ~sclPrev;
  assign sclFall   = ~sclS & sclPrev;
  assign startSeen = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopSeen  = sclS & sclPrev & ~sdaPrev & sdaS;

  busState_t state;
  logic [3:0] bitCnt;
  logic [7:0] rxShift, txShift;
  logic ackPhase, okLatch, wpLatch, rdSel, drvLow;
  logic active, byteEnd, ackEnd, okNow;

  assign active  = (state != ST_IDLE) && (state != ST_SKIP);
  assign byteEnd = sclFall && active && !ackPhase && (bitCnt == 4'd8);
  assign ackEnd  = sclFall && active && ackPhase;

  always_comb begin
    case (state)
      ST_ADDR: okNow = (rxShift[7:1] == DEV_ADDR) && !busy;
      ST_CMD:  okNow = (rxShift == CMD_DAC) || (rxShift == CMD_STORE);
      ST_DATA: okNow = 1'b1;
      default: okNow = 1'b0;
    endcase
  end

  assign strobe.dacWr   = byteEnd && (state == ST_DATA) && wpLatch;
  assign strobe.storeWr = byteEnd && (state == ST_CMD) && (rxShift == CMD_STORE) && wpLatch;
  assign strobe.code    = rxShift[CODE_W-1:0];
  assign sdaPullLow     = drvLow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      rxShift  <= '0;
      txShift  <= '0;
      ackPhase <= 1'b0;
      okLatch  <= 1'b0;
      wpLatch  <= 1'b0;
      rdSel    <= 1'b0;
      drvLow   <= 1'b0;
    end else if (stopSeen) begin
      state    <= ST_IDLE;
      ackPhase <= 1'b0;
      drvLow   <= 1'b0;
    end else if (startSeen) begin
      state    <= ST_ADDR;
      bitCnt   <= '0;
      ackPhase <= 1'b0;
      drvLow   <= 1'b0;
    end else begin
      if (sclRise && active) begin
        if (ackPhase) begin
          if (state == ST_READ) okLatch <= ~sdaS;
        end else if (bitCnt < 4'd8) begin
          rxShift <= {rxShift[6:0], sdaS};
          bitCnt  <= bitCnt + 4'd1;
          if (bitCnt == 4'd7) wpLatch <= wpIn;
        end
      end
      if (byteEnd) begin
        ackPhase <= 1'b1;
        okLatch  <= okNow;
        drvLow   <= okNow;
      end else if (ackEnd) begin
        ackPhase <= 1'b0;
        bitCnt   <= '0;
        drvLow   <= 1'b0;
        if (!okLatch) begin
          state <= ST_SKIP;
        end else begin
          case (state)
            ST_ADDR: begin
              if (rxShift[0]) begin
                state   <= ST_READ;
                txShift <= {1'b0, dacCode};
                drvLow  <= 1'b1;
                rdSel   <= 1'b1;
              end else begin
                state <= ST_CMD;
              end
            end
            ST_CMD:  state <= (rxShift == CMD_DAC) ? ST_DATA : ST_SKIP;
            ST_READ: begin
              txShift <= rdSel ? {1'b0, nvCode} : {1'b0, dacCode};
              drvLow  <= 1'b1;
              rdSel   <= ~rdSel;
            end
            default: ;
          endcase
        end
      end else if (sclFall && (state == ST_READ) && !ackPhase && (bitCnt < 4'd8)) begin
        txShift <= {txShift[6:0], 1'b0};
        drvLow  <= ~txShift[6];
      end
    end
  end

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> !sdaPullLow); // R2

  AST_NO_ACK_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (byteEnd && (state == ST_ADDR) && busy) |=> !sdaPullLow); // R10

  AST_DRIVE_CHANGES_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(drvLow) && !$past(startSeen) && !$past(stopSeen)) |-> !$past(sclS)); // R3
endmodule

// File: rtl/calib_data.sv
module calib_data
  import calib_pkg::*;
#(
  parameter int                STORE_CYCLES = 2000,
  parameter logic [CODE_W-1:0] NV_INIT      = 7'd64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              porN,
  input  calStrobe_t        strobe,
  output logic [CODE_W-1:0] dacCode,
  output logic [CODE_W-1:0] nvCode,
  output logic              busy
);
  localparam int BUSY_W = $clog2(STORE_CYCLES + 1);

  logic [CODE_W-1:0] dacQ, nvQ;
  logic [BUSY_W-1:0] busyCnt;

  always_ff @(posedge clk) begin
    if (!porN) nvQ <= NV_INIT;
    else if (rstN && strobe.storeWr) nvQ <= dacQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) dacQ <= nvQ;
    else if (strobe.dacWr) dacQ <= strobe.code;
  end

  always_ff @(posedge clk) begin
    if (!rstN) busyCnt <= '0;
    else if (strobe.storeWr) busyCnt <= BUSY_W'(STORE_CYCLES);
    else if (busyCnt != '0) busyCnt <= busyCnt - 1'b1;
  end

  assign dacCode = dacQ;
  assign nvCode  = nvQ;
  assign busy    = (busyCnt != '0);

  AST_DAC_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN || !porN)
    ($past(rstN) && !$stable(dacQ)) |-> $past(strobe.dacWr)); // R4

  AST_NV_ONLY_ON_STORE: assert property (@(posedge clk) disable iff (!rstN || !porN)
    ($past(porN) && !$stable(nvQ)) |-> $past(strobe.storeWr)); // R5

  AST_BUSY_AFTER_STORE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.storeWr |=> busy); // R10

  AST_RECALL_ON_RESET: assert property (@(posedge clk) disable iff (!porN)
    ($past(!rstN) && rstN) |-> (dacQ == nvQ)); // R7
endmodule

// File: rtl/calib_i2c_slave.sv
module calib_i2c_slave
  import calib_pkg::*;
#(
  parameter logic [6:0]        DEV_ADDR     = 7'b1001111,
  parameter int                STORE_CYCLES = 2000,
  parameter logic [CODE_W-1:0] NV_INIT      = 7'd64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              porN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              wpIn,
  output logic              sdaPullLow,
  output logic [CODE_W-1:0] dacCode,
  output logic              storeBusy
);
  calStrobe_t        strobe;
  logic [CODE_W-1:0] nvCode;

  calib_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .wpIn(wpIn),
    .busy(storeBusy), .dacCode(dacCode), .nvCode(nvCode),
    .sdaPullLow(sdaPullLow), .strobe(strobe)
  );

  calib_data #(.STORE_CYCLES(STORE_CYCLES), .NV_INIT(NV_INIT)) u_data (
    .clk(clk), .rstN(rstN), .porN(porN), .strobe(strobe),
    .dacCode(dacCode), .nvCode(nvCode), .busy(storeBusy)
  );
endmodule

// File: tb/calib_i2c_slave_bench.sv
module calib_i2c_slave_bench;
  localparam int Q = 8;
  localparam int STORE_CYC = 2000;
  localparam logic [7:0] AW = 8'h9E;
  localparam logic [7:0] AR = 8'h9F;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, porN, sclM, sdaM, wp, sdaPull, busy;
  logic [6:0] dac;
  wire sdaLine = sdaM & ~sdaPull;
  int nChk = 0;
  int nFail = 0;

  calib_i2c_slave u_calib_i2c_slave (
    .clk(clk), .rstN(rstN), .porN(porN), .sclIn(sclM), .sdaIn(sdaLine),
    .wpIn(wp), .sdaPullLow(sdaPull), .dacCode(dac), .storeBusy(busy)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic busStart();
    sdaM = 1'b1; sclM = 1'b1; tick(2*Q);
    sdaM = 1'b0; tick(2*Q);
    sclM = 1'b0; tick(Q);
  endtask

  task automatic busRestart();
    sdaM = 1'b1; tick(2*Q);
    sclM = 1'b1; tick(2*Q);
    sdaM = 1'b0; tick(2*Q);
    sclM = 1'b0; tick(Q);
  endtask

  task automatic busStop();
    sdaM = 1'b0; tick(Q);
    sclM = 1'b1; tick(2*Q);
    sdaM = 1'b1; tick(2*Q);
  endtask

  task automatic clockBit(input logic bi, output logic bo);
    sdaM = bi; tick(Q);
    sclM = 1'b1; tick(Q);
    bo = sdaLine; tick(Q);
    sclM = 1'b0; tick(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    logic d;
    for (int i = 7; i >= 0; i--) clockBit(b[i], d);
    clockBit(1'b1, d);
    ack = ~d;
  endtask

  task automatic readByte(input logic mAck, output logic [7:0] b);
    logic d;
    for (int i = 7; i >= 0; i--) clockBit(1'b1, b[i]);
    clockBit(~mAck, d);
  endtask

  task automatic writeDac(input logic [7:0] code);
    logic a;
    busStart(); sendByte(AW, a); sendByte(8'h00, a); sendByte(code, a); busStop();
  endtask

  task automatic readBoth(output logic [7:0] d, output logic [7:0] n);
    logic a;
    busStart(); sendByte(AR, a); readByte(1'b1, d); readByte(1'b0, n); busStop();
  endtask

  task automatic tReset();
    porN = 1'b0; rstN = 1'b0; tick(6);
    porN = 1'b1; rstN = 1'b1; tick(2);
    chk("R7 reset code", dac, 64);
    chk("R2 idle pull", sdaPull, 0);
    chk("R10 idle busy", busy, 0);
  endtask

  task automatic tWriteDac();
    logic a;
    busStart();
    sendByte(AW, a); chk("R1 addr ack", a, 1);
    sendByte(8'h00, a); chk("R3 cmd ack", a, 1);
    sendByte(8'h25, a); chk("R4 data ack", a, 1);
    chk("R4 code 0x25", dac, 8'h25);
    sendByte(8'hFF, a); chk("R4 second byte ack", a, 1);
    chk("R4 bit7 ignored", dac, 8'h7F);
    busStop();
    chk("R2 released after stop", sdaPull, 0);
  endtask

  task automatic tWrongAddr();
    logic a;
    busStart();
    sendByte(8'h9C, a); chk("R1 wrong addr nack", a, 0);
    sendByte(8'h00, a); chk("R1 ignored cmd", a, 0);
    sendByte(8'h01, a); chk("R1 ignored data", a, 0);
    busStop();
    chk("R1 code untouched", dac, 8'h7F);
  endtask

  task automatic tRead();
    logic a;
    logic [7:0] b;
    writeDac(8'h2A);
    busStart();
    sendByte(AR, a); chk("R1 read addr ack", a, 1);
    readByte(1'b1, b); chk("R8 first byte live", b, 8'h2A);
    readByte(1'b1, b); chk("R8 second byte stored", b, 64);
    readByte(1'b0, b); chk("R8 third byte live", b, 8'h2A);
    readByte(1'b1, b); chk("R9 released after nack", b, 8'hFF);
    busStop();
  endtask

  task automatic tStore();
    logic a;
    logic [7:0] d, n;
    writeDac(8'h11);
    busStart();
    sendByte(AW, a); sendByte(8'h80, a); chk("R5 store cmd ack", a, 1);
    busStop();
    chk("R10 busy raised", busy, 1);
    busStart(); sendByte(AW, a); chk("R10 addr nack while busy", a, 0); busStop();
    tick(STORE_CYC);
    chk("R10 busy cleared", busy, 0);
    readBoth(d, n);
    chk("R5 stored code", n, 8'h11);
    chk("R8 live code", d, 8'h11);
  endtask

  task automatic tProtect();
    logic a;
    logic [7:0] d, n;
    writeDac(8'h44);
    wp = 1'b0;
    busStart(); sendByte(AW, a); sendByte(8'h00, a);
    sendByte(8'h33, a); chk("R6 protected data ack", a, 1);
    busStop();
    chk("R6 code unchanged", dac, 8'h44);
    busStart(); sendByte(AW, a);
    sendByte(8'h80, a); chk("R6 protected store ack", a, 1);
    busStop();
    chk("R6 no busy", busy, 0);
    readBoth(d, n);
    chk("R6 store unchanged", n, 8'h11);
    wp = 1'b1;
  endtask

  task automatic tBadCmd();
    logic a;
    busStart(); sendByte(AW, a);
    sendByte(8'h42, a); chk("R11 bad cmd nack", a, 0);
    sendByte(8'h00, a); chk("R11 rest ignored", a, 0);
    busStop();
    chk("R11 code unchanged", dac, 8'h44);
  endtask

  task automatic tRestart();
    logic a;
    logic [7:0] b;
    busStart(); sendByte(AW, a); sendByte(8'h00, a);
    busRestart();
    sendByte(AR, a); chk("R2 restart addr ack", a, 1);
    readByte(1'b0, b); chk("R2 read after restart", b, 8'h44);
    busStop();
    chk("R2 released", sdaPull, 0);
  endtask

  task automatic tRecall();
    rstN = 1'b0; tick(4);
    rstN = 1'b1; tick(2);
    chk("R7 recall stored", dac, 8'h11);
  endtask

  initial begin
    sclM = 1'b1; sdaM = 1'b1; wp = 1'b1; rstN = 1'b0; porN = 1'b0;
    tReset();
    tWriteDac();
    tWrongAddr();
    tRead();
    tStore();
    tProtect();
    tBadCmd();
    tRestart();
    tRecall();
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule